// File: doc/BRIEF.md
# Tamper Response Boot Sequencer

This block is the control sequencer of a tamper-evident enclosure that carries a capacitive sensor mesh. After a power-on reset it puts the device through a fixed boot order. First comes a fast open/short integrity check of the mesh. A first-tier tamper check follows, repeated a set number of times. The block then requests derivation of a key from the enclosure response and, if that succeeds, decryption of the stored secret parameters. Three trust levels mark the progress: unverified, preverified and fully verified.

Once fully verified, the block runs a heartbeat of programmable period. Each beat queues an integrity check and a second-tier check, which applies rate and range limits to the differential capacitance. Every N-th beat also queues a third-tier check on absolute capacitance. Only one measurement may be open at a time, and a small arbiter orders the queued kinds with integrity first.

Any failed check, a failed key derivation, a failed decryption, or a measurement that gets no answer in time counts as tamper. Each of these raises a zeroize output, which holds until the next reset.

Top module: `tamper_boot_seq`

## Requirements
- R1: While reset is held, and on the cycle after it, `trust_state` is 00, `zeroize` is low and all three request outputs are low.
- R2: After reset the first measurement request carries kind code 0 (integrity), and no key request appears before the integrity and first-tier checks have passed.
- R3: After the integrity check passes, exactly TIER_A_REPEATS measurements of kind code 1 (first tier) are issued one after another.
- R4: The result of the last first-tier check is taken one cycle after its done. If it passes, `trust_state` becomes 01 and `key_req` rises on that same cycle.
- R5: A passing key answer ends `key_req` and raises `dec_req` on the next cycle. A passing decrypt answer sets `trust_state` to 10 on the next cycle.
- R6: While in state 10, heartbeats occur every HEARTBEAT_CYCLES cycles. Each beat queues kind 0 and kind 2 (second tier), and kind 0 is granted first.
- R7: Every C_EVERY-th heartbeat also queues kind 3 (third tier), which is granted after kind 2.
- R8: At most one of `meas_req`, `key_req` and `dec_req` is high at a time. A measurement request stays high with a stable kind until its done is taken or it times out.
- R9: A measurement done with `meas_pass` low makes `zeroize` high and `trust_state` 11 two cycles after the done edge. From then on all request outputs stay low.
- R10: A key answer or a decrypt answer with its pass bit low sets `zeroize` and `trust_state` 11 on the next cycle.
- R11: A measurement request is answered in time if done arrives on any of the TIMEOUT_CYCLES clock edges after the request rises. Otherwise `zeroize` follows.
- R12: Once high, `zeroize` and `trust_state` 11 stay until reset, whatever happens on the done and pass inputs.
- R13: A done or pass on a handshake whose request is low has no effect on state or outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| meas_req | output | 1 | Measurement request, held until done |
| meas_kind | output | 2 | Requested check: 0 integrity, 1 first tier, 2 second tier, 3 third tier |
| meas_done | input | 1 | Measurement finished |
| meas_pass | input | 1 | Measurement result good, valid with done |
| key_req | output | 1 | Key derivation request |
| key_done | input | 1 | Key derivation finished |
| key_pass | input | 1 | Key derivation succeeded |
| dec_req | output | 1 | Decryption request for stored secrets |
| dec_done | input | 1 | Decryption finished |
| dec_pass | input | 1 | Decryption succeeded |
| zeroize | output | 1 | Wipe command for secret storage, sticky |
| trust_state | output | 2 | 00 unverified, 01 preverified, 10 fully verified, 11 zeroized |

## Verification
A wrong phase or a skipped count shows first at `meas_kind`. The next granted request then carries the wrong code, so the error is visible within a few cycles of the previous done. A trust level that is wrong or late appears at `trust_state` on the exact cycle the bench predicts from the last done it answered. A lost or spurious tamper decision moves `zeroize` one or two cycles from its cause. Heartbeat drift shows as a change in the spacing of successive integrity grants, measured to the cycle.

// File: rtl/tbs_pkg.sv
package tbs_pkg;

    localparam int NUM_CHK = 4;

    typedef enum logic [1:0] {
        TRUST_UNVER = 2'b00,
        TRUST_PRE   = 2'b01,
        TRUST_FULL  = 2'b10,
        TRUST_ZERO  = 2'b11
    } trust_e;

    // Index order is also arbitration priority: lower index wins.
    typedef enum logic [1:0] {
        CHK_INTEG  = 2'd0,
        CHK_TIER_A = 2'd1,
        CHK_TIER_B = 2'd2,
        CHK_TIER_C = 2'd3
    } chk_e;

    typedef enum logic [2:0] {
        PH_START,
        PH_INTEG,
        PH_TIERA,
        PH_KEY,
        PH_DEC,
        PH_RUN,
        PH_ZERO
    } phase_e;

    typedef struct packed {
        logic valid;
        logic pass;
        chk_e kind;
    } meas_res_t;

    function automatic logic [NUM_CHK-1:0] chk_bit(chk_e k);
        return NUM_CHK'(1) << k;
    endfunction

    function automatic chk_e chk_pick(logic [NUM_CHK-1:0] pend);
        chk_e r;
        r = CHK_INTEG;
        for (int i = NUM_CHK - 1; i >= 0; i--) begin
            if (pend[i]) r = chk_e'(2'(i));
        end
        return r;
    endfunction

endpackage

// File: rtl/tbs_meas_arb.sv
module tbs_meas_arb
    import tbs_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               kill,
    input  logic [NUM_CHK-1:0] post,
    input  logic               meas_done,
    input  logic               meas_pass,
    output logic               meas_req,
    output chk_e               meas_kind,
    output meas_res_t          res,
    output logic               timeout
);

    localparam int WW = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [WW-1:0] WAIT_LAST = WW'(TIMEOUT_CYCLES - 1);

    logic [NUM_CHK-1:0] pend_q;
    logic [NUM_CHK-1:0] pend_d;
    logic [NUM_CHK-1:0] grant;
    logic               busy_q;
    chk_e               kind_q;
    logic [WW-1:0]      wait_q;
    meas_res_t          res_q;
    logic               tout_q;

    always_comb begin
        grant = '0;
        if (!busy_q && (|pend_q)) grant = chk_bit(chk_pick(pend_q));
    end

    for (genvar g = 0; g < NUM_CHK; g++) begin : g_pend
        assign pend_d[g] = (pend_q[g] & ~grant[g]) | post[g];
    end

    always_ff @(posedge clk) begin
        if (rst || kill) pend_q <= '0;
        else             pend_q <= pend_d;
    end

    always_ff @(posedge clk) begin
        if (rst || kill) begin
            busy_q <= 1'b0;
            kind_q <= CHK_INTEG;
            wait_q <= '0;
            res_q  <= '0;
            tout_q <= 1'b0;
        end else begin
            res_q.valid <= 1'b0;
            tout_q      <= 1'b0;
            if (busy_q) begin
                if (meas_done) begin
                    busy_q <= 1'b0;
                    res_q  <= '{valid: 1'b1, pass: meas_pass, kind: kind_q};
                end else if (wait_q == WAIT_LAST) begin
                    busy_q <= 1'b0;
                    tout_q <= 1'b1;
                end else begin
                    wait_q <= wait_q + 1'b1;
                end
            end else if (|pend_q) begin
                busy_q <= 1'b1;
                kind_q <= chk_pick(pend_q);
                wait_q <= '0;
            end
        end
    end

    assign meas_req  = busy_q;
    assign meas_kind = kind_q;
    assign res       = res_q;
    assign timeout   = tout_q;

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (busy_q && !meas_done && !kill && wait_q != WAIT_LAST) |=> (busy_q && $stable(kind_q)))
        else $error("open request dropped or kind changed");

    assert_single_grant_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant))
        else $error("more than one grant");

    assert_timeout_src_R11: assert property (@(posedge clk) disable iff (rst)
        tout_q |-> $past(busy_q && !meas_done))
        else $error("timeout without open request");

endmodule

// File: rtl/tbs_heartbeat.sv
module tbs_heartbeat #(
    parameter int HEARTBEAT_CYCLES = 64,
    parameter int C_EVERY          = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic beat,
    output logic beat_c
);

    localparam int CW = $clog2(HEARTBEAT_CYCLES);
    localparam int IW = (C_EVERY > 1) ? $clog2(C_EVERY) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(HEARTBEAT_CYCLES - 1);
    localparam logic [IW-1:0] IDX_LAST = IW'(C_EVERY - 1);

    logic [CW-1:0] cnt_q;
    logic [IW-1:0] idx_q;
    logic          beat_q;
    logic          beat_c_q;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q    <= '0;
            idx_q    <= '0;
            beat_q   <= 1'b0;
            beat_c_q <= 1'b0;
        end else begin
            beat_q   <= 1'b0;
            beat_c_q <= 1'b0;
            if (cnt_q == CNT_LAST) begin
                cnt_q    <= '0;
                beat_q   <= 1'b1;
                beat_c_q <= (idx_q == IDX_LAST);
                idx_q    <= (idx_q == IDX_LAST) ? '0 : idx_q + 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign beat   = beat_q;
    assign beat_c = beat_c_q;

    assert_c_on_beat_R7: assert property (@(posedge clk) disable iff (rst)
        beat_c |-> beat)
        else $error("third-tier beat outside a heartbeat");

endmodule

// File: rtl/tbs_core.sv
module tbs_core
    import tbs_pkg::*;
#(
    parameter int TIER_A_REPEATS = 3
) (
    input  logic               clk,
    input  logic               rst,
    input  meas_res_t          res,
    input  logic               timeout,
    input  logic               beat,
    input  logic               beat_c,
    input  logic               key_done,
    input  logic               key_pass,
    input  logic               dec_done,
    input  logic               dec_pass,
    output logic [NUM_CHK-1:0] post,
    output logic               key_req,
    output logic               dec_req,
    output logic               zeroize,
    output trust_e             trust,
    output logic               kill,
    output logic               run_en
);

    localparam int AW = $clog2(TIER_A_REPEATS + 1);
    localparam logic [AW-1:0] A_FULL = AW'(TIER_A_REPEATS);

    phase_e             phase_q;
    trust_e             trust_q;
    logic               zero_q;
    logic               key_req_q;
    logic               dec_req_q;
    logic [NUM_CHK-1:0] post_q;
    logic [AW-1:0]      a_left_q;
    logic               fail_now;

    always_comb begin
        fail_now = 1'b0;
        if (!zero_q) begin
            if (res.valid && !res.pass)                 fail_now = 1'b1;
            if (timeout)                                fail_now = 1'b1;
            if (key_req_q && key_done && !key_pass)     fail_now = 1'b1;
            if (dec_req_q && dec_done && !dec_pass)     fail_now = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q   <= PH_START;
            trust_q   <= TRUST_UNVER;
            zero_q    <= 1'b0;
            key_req_q <= 1'b0;
            dec_req_q <= 1'b0;
            post_q    <= '0;
            a_left_q  <= A_FULL;
        end else if (zero_q) begin
            post_q    <= '0;
            key_req_q <= 1'b0;
            dec_req_q <= 1'b0;
        end else if (fail_now) begin
            phase_q   <= PH_ZERO;
            trust_q   <= TRUST_ZERO;
            zero_q    <= 1'b1;
            key_req_q <= 1'b0;
            dec_req_q <= 1'b0;
            post_q    <= '0;
        end else begin
            post_q <= '0;
            unique case (phase_q)
                PH_START: begin
                    post_q  <= chk_bit(CHK_INTEG);
                    phase_q <= PH_INTEG;
                end
                PH_INTEG: begin
                    if (res.valid) begin
                        post_q   <= chk_bit(CHK_TIER_A);
                        a_left_q <= A_FULL;
                        phase_q  <= PH_TIERA;
                    end
                end
                PH_TIERA: begin
                    if (res.valid) begin
                        if (a_left_q == AW'(1)) begin
                            trust_q   <= TRUST_PRE;
                            key_req_q <= 1'b1;
                            phase_q   <= PH_KEY;
                        end else begin
                            a_left_q <= a_left_q - 1'b1;
                            post_q   <= chk_bit(CHK_TIER_A);
                        end
                    end
                end
                PH_KEY: begin
                    if (key_done) begin
                        key_req_q <= 1'b0;
                        dec_req_q <= 1'b1;
                        phase_q   <= PH_DEC;
                    end
                end
                PH_DEC: begin
                    if (dec_done) begin
                        dec_req_q <= 1'b0;
                        trust_q   <= TRUST_FULL;
                        phase_q   <= PH_RUN;
                    end
                end
                PH_RUN: begin
                    if (beat) begin
                        post_q <= chk_bit(CHK_INTEG) | chk_bit(CHK_TIER_B)
                                | (beat_c ? chk_bit(CHK_TIER_C) : '0);
                    end
                end
                default: ;
            endcase
        end
    end

    assign post    = post_q;
    assign key_req = key_req_q;
    assign dec_req = dec_req_q;
    assign zeroize = zero_q;
    assign trust   = trust_q;
    assign kill    = zero_q | fail_now;
    assign run_en  = (phase_q == PH_RUN);

    assert_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        zero_q |=> (zero_q && trust_q == TRUST_ZERO))
        else $error("zeroize released without reset");

    assert_key_in_pre_R4: assert property (@(posedge clk) disable iff (rst)
        key_req_q |-> (trust_q == TRUST_PRE))
        else $error("key request outside preverified");

    assert_full_from_dec_R5: assert property (@(posedge clk) disable iff (rst)
        (trust_q == TRUST_FULL && $past(trust_q) != TRUST_FULL)
            |-> $past(dec_req_q && dec_done && dec_pass))
        else $error("fully verified without decrypt success");

    assert_keyfail_R10: assert property (@(posedge clk) disable iff (rst)
        (key_req_q && key_done && !key_pass) |=> zero_q)
        else $error("key failure not treated as tamper");

endmodule

// File: rtl/tamper_boot_seq.sv
module tamper_boot_seq
    import tbs_pkg::*;
#(
    parameter int TIER_A_REPEATS   = 3,
    parameter int HEARTBEAT_CYCLES = 64,
    parameter int TIMEOUT_CYCLES   = 32,
    parameter int C_EVERY          = 4
) (
    input  logic       clk,
    input  logic       rst,
    output logic       meas_req,
    output logic [1:0] meas_kind,
    input  logic       meas_done,
    input  logic       meas_pass,
    output logic       key_req,
    input  logic       key_done,
    input  logic       key_pass,
    output logic       dec_req,
    input  logic       dec_done,
    input  logic       dec_pass,
    output logic       zeroize,
    output logic [1:0] trust_state
);

    logic [NUM_CHK-1:0] post;
    logic               kill;
    logic               run_en;
    logic               beat;
    logic               beat_c;
    logic               tout;
    meas_res_t          res;
    chk_e               kind;
    trust_e             trust;

    tbs_meas_arb #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) arb_i (
        .clk       (clk),
        .rst       (rst),
        .kill      (kill),
        .post      (post),
        .meas_done (meas_done),
        .meas_pass (meas_pass),
        .meas_req  (meas_req),
        .meas_kind (kind),
        .res       (res),
        .timeout   (tout)
    );

    tbs_heartbeat #(.HEARTBEAT_CYCLES(HEARTBEAT_CYCLES), .C_EVERY(C_EVERY)) hb_i (
        .clk    (clk),
        .rst    (rst),
        .en     (run_en),
        .beat   (beat),
        .beat_c (beat_c)
    );

    tbs_core #(.TIER_A_REPEATS(TIER_A_REPEATS)) core_i (
        .clk      (clk),
        .rst      (rst),
        .res      (res),
        .timeout  (tout),
        .beat     (beat),
        .beat_c   (beat_c),
        .key_done (key_done),
        .key_pass (key_pass),
        .dec_done (dec_done),
        .dec_pass (dec_pass),
        .post     (post),
        .key_req  (key_req),
        .dec_req  (dec_req),
        .zeroize  (zeroize),
        .trust    (trust),
        .kill     (kill),
        .run_en   (run_en)
    );

    assign meas_kind   = kind;
    assign trust_state = trust;

    assert_zero_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        zeroize |=> (!meas_req && !key_req && !dec_req && trust_state == 2'b11))
        else $error("activity after zeroize");

    assert_one_req_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({meas_req, key_req, dec_req}))
        else $error("more than one handshake open");

endmodule

// File: tb/tamper_boot_seq_tb_top.sv
`timescale 1ns/1ps
module tamper_boot_seq_tb_top;

    localparam int REP = 3;
    localparam int HB  = 64;
    localparam int TO  = 32;
    localparam int CE  = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic meas_req, key_req, dec_req, zeroize;
    logic [1:0] meas_kind, trust_state;
    logic meas_done = 0, meas_pass = 0;
    logic key_done = 0, key_pass = 0;
    logic dec_done = 0, dec_pass = 0;

    always #2.5 clk = ~clk;

    tamper_boot_seq #(.TIER_A_REPEATS(REP), .HEARTBEAT_CYCLES(HB),
                      .TIMEOUT_CYCLES(TO), .C_EVERY(CE)) dut_i (
        .clk(clk), .rst(rst),
        .meas_req(meas_req), .meas_kind(meas_kind),
        .meas_done(meas_done), .meas_pass(meas_pass),
        .key_req(key_req), .key_done(key_done), .key_pass(key_pass),
        .dec_req(dec_req), .dec_done(dec_done), .dec_pass(dec_pass),
        .zeroize(zeroize), .trust_state(trust_state)
    );

    int checks = 0;
    int errors = 0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // responder configuration (changed only while reset is held)
    int lat = 1;
    int fail_at = -1;
    bit stall = 0, key_ok = 1, dec_ok = 1, chaos = 0, stray_pend = 0;

    // reference model state
    int cyc = 0, idx = 0, seen = 0, zcd = 0, pcd = 0, fcd = 0, rst_seen = 0, last_i = 0;
    logic [1:0] m_trust = 0;
    bit m_zero = 0, allow_key = 0, allow_dec = 0, c_seen = 0, stray_hit = 0;

    function automatic int exp_kind(int i);
        int pos;
        if (i == 0) return 0;
        if (i <= REP) return 1;
        pos = i - REP - 1;
        for (int b = 1; b < 10000; b++) begin
            int n;
            n = (b % CE == 0) ? 3 : 2;
            if (pos < n) return (pos == 0) ? 0 : ((pos == 1) ? 2 : 3);
            pos -= n;
        end
        return -1;
    endfunction

    function automatic string trust_tag(logic [1:0] t);
        case (t)
            2'b00: return "R1";
            2'b01: return "R4";
            2'b10: return "R5";
            default: return "R9";
        endcase
    endfunction

    always @(negedge clk) begin
        cyc++;
        meas_done = 0; meas_pass = 0; key_done = 0; key_pass = 0; dec_done = 0; dec_pass = 0;
        if (rst) begin
            rst_seen++;
            m_trust = 0; m_zero = 0; zcd = 0; pcd = 0; fcd = 0; idx = 0; seen = 0;
            allow_key = 0; allow_dec = 0; last_i = 0;
            if (rst_seen >= 2) begin
                chk(trust_state == 2'b00, "R1", trust_state, 0);
                chk(!zeroize && !meas_req && !key_req && !dec_req, "R1",
                    {zeroize, meas_req, key_req, dec_req}, 0);
            end
        end else begin
            rst_seen = 0;
            if (zcd > 0) begin zcd--; if (zcd == 0) begin m_zero = 1; m_trust = 2'b11; allow_key = 0; allow_dec = 0; end end
            if (pcd > 0) begin pcd--; if (pcd == 0 && !m_zero) begin m_trust = 2'b01; allow_key = 1; end end
            if (fcd > 0) begin fcd--; if (fcd == 0 && !m_zero) m_trust = 2'b10; end

            chk(trust_state == m_trust, trust_tag(m_trust), trust_state, m_trust);
            chk(zeroize == m_zero, m_zero ? "R12" : "R9", zeroize, m_zero);
            if (m_zero) chk(!meas_req && !key_req && !dec_req, "R9",
                            {meas_req, key_req, dec_req}, 0);
            if (key_req) chk(allow_key, "R2", key_req, allow_key);
            if (dec_req) chk(allow_dec, "R5", dec_req, allow_dec);
            chk($countones({meas_req, key_req, dec_req}) <= 1, "R8",
                $countones({meas_req, key_req, dec_req}), 1);

            if (m_zero) begin
                if (chaos) begin
                    meas_done = cyc[0]; meas_pass = 1; key_done = 1; key_pass = 1;
                    dec_done = ~cyc[0]; dec_pass = 1;
                end
            end else if (zcd == 0) begin
                if (meas_req) begin
                    seen++;
                    if (stall) begin
                        if (seen == TO) zcd = 2;
                    end else if (seen == lat) begin
                        int ek;
                        ek = exp_kind(idx);
                        chk(int'(meas_kind) == ek,
                            (idx == 0) ? "R2" : (idx <= REP) ? "R3" : (ek == 3) ? "R7" : "R6",
                            meas_kind, ek);
                        if (ek == 3) c_seen = 1;
                        if (idx > REP && ek == 0) begin
                            if (last_i > 0) chk(cyc - last_i == HB, "R6", cyc - last_i, HB);
                            last_i = cyc;
                        end
                        meas_done = 1;
                        meas_pass = (idx != fail_at);
                        if (idx == fail_at) zcd = 2;
                        else if (idx == REP) pcd = 2;
                        idx++;
                        seen = 0;
                    end
                end else begin
                    seen = 0;
                    if (stray_pend && m_trust == 2'b10 && !key_req && !dec_req) begin
                        meas_done = 1; meas_pass = 0; key_done = 1; dec_done = 1;
                        stray_pend = 0; stray_hit = 1;
                    end
                end
                if (key_req) begin
                    key_done = 1; key_pass = key_ok; allow_key = 0;
                    if (key_ok) allow_dec = 1; else zcd = 1;
                end
                if (dec_req) begin
                    dec_done = 1; dec_pass = dec_ok; allow_dec = 0;
                    if (dec_ok) fcd = 1; else zcd = 1;
                end
            end
        end
    end

    task automatic restart(input int l, input int f, input bit st, input bit ko,
                           input bit dok, input bit ch, input bit stray);
        @(negedge clk);
        rst <= 1;
        repeat (3) @(negedge clk);
        lat <= l; fail_at <= f; stall <= st; key_ok <= ko; dec_ok <= dok;
        chaos <= ch; stray_pend <= stray;
        @(negedge clk);
        rst <= 0;
    endtask

    initial begin
        // normal boot, run mode, stray done while idle
        restart(1, -1, 0, 1, 1, 0, 1);
        repeat (450) @(negedge clk);
        chk(c_seen, "R7", c_seen, 1);
        chk(stray_hit, "R13", stray_hit, 1);
        chk(trust_state == 2'b10 && !zeroize, "R13", {zeroize, trust_state}, 2);

        // key derivation failure
        restart(1, -1, 0, 0, 1, 0, 0);
        repeat (60) @(negedge clk);
        chk(zeroize == 1 && trust_state == 2'b11, "R10", {zeroize, trust_state}, 7);

        // decryption failure
        restart(2, -1, 0, 1, 0, 0, 0);
        repeat (60) @(negedge clk);
        chk(zeroize == 1 && trust_state == 2'b11, "R10", {zeroize, trust_state}, 7);

        // second first-tier check fails, then inputs toggled hard
        restart(1, 2, 0, 1, 1, 1, 0);
        repeat (80) @(negedge clk);
        chk(zeroize == 1, "R12", zeroize, 1);
        chk(trust_state == 2'b11, "R9", trust_state, 3);

        // no answer to the first request
        restart(1, -1, 1, 1, 1, 0, 0);
        repeat (60) @(negedge clk);
        chk(zeroize == 1, "R11", zeroize, 1);

        // third-tier check fails in run mode
        restart(3, 12, 0, 1, 1, 0, 0);
        repeat (400) @(negedge clk);
        chk(zeroize == 1 && c_seen, "R7", zeroize, 1);

        // answers on the last accepted edge
        restart(TO, -1, 0, 1, 1, 0, 0);
        repeat (190) @(negedge clk);
        chk(trust_state == 2'b10 && !zeroize, "R11", {zeroize, trust_state}, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule